// File: doc/BRIEF.md
# Four-Pair Power Policing Threshold Controller

This block holds the summed four-pair power cut-off threshold for one port pair and decides when that port has drawn too much power for too long. A host reads and writes an 8-bit threshold code in which one LSB is 0.5 W. When the port powers up in an automatic or semi-automatic operating mode, the code is filled in from the assigned class. For a dual-signature load the code is the sum of the two channels' class codes. The code returns to all-ones whenever the port goes off, whether a command or a fault turned it off.

The summed power of the port arrives as a digital sample in the same 0.5 W units. The block compares the sample against the effective threshold, which is the stored code raised to a 4 W floor. A 1 ms tick times how long an overload lasts. If the overload outlasts the configured overload time plus a fixed extra margin, the block emits a one-cycle fault pulse. That pulse also drops the port's powered state and resets the threshold code.

Top module: `ppol_ctrl`

## Requirements
- R1: After reset the threshold readback is 0xFF, the fault and overload outputs are low, and policing is not armed.
- R2: A host write stores its byte, and the readback returns that byte unchanged, including codes below 8.
- R3: A power-on event with mode 2 (semi-automatic) or 3 (automatic) and a single-signature load loads the class code: class 1 = 0x08, class 2 = 0x0E, class 3 = 0x1F, class 4 = 0x3C, class 5 = 0x5A, class 6 = 0x78, class 7 = 0x96, class 8 = 0xB4. Any other class value loads 0xFF.
- R4: With the dual-signature input high, the power-on load is the sum of the codes of class A and class B, saturated at 0xFF.
- R5: A power-on event leaves the stored code unchanged when the keep-host-value input is high, or when the mode is 0 (off) or 1 (manual).
- R6: A host write in the same cycle as a loading power-on event takes priority over the class load.
- R7: A port-off event or a fault returns the code to 0xFF on the next clock edge. A port-off event takes priority over a host write in the same cycle.
- R8: A stored code below 8 is compared as 8 (4 W). Power 8 is not an overload and power 9 is.
- R9: The comparison is strictly greater-than, so power equal to the effective threshold is not an overload.
- R10: A continuous overload lasting (overload ms + 6) ticks raises fault_o for exactly one cycle, on the clock edge after the last of those ticks.
- R11: The overload timer clears in any cycle in which power is at or below the threshold, and a later overload counts from zero again.
- R12: Policing is armed only while the port is powered, the mode is 2 or 3, and the load is single-signature or the four-pair enable is set. While policing is not armed, overload_o stays low and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe for the threshold code |
| host_wdata_i | input | 8 | Host write data |
| thr_o | output | 8 | Threshold code readback |
| mode_i | input | 2 | Operating mode: 0 off, 1 manual, 2 semi-automatic, 3 automatic |
| pwr_on_i | input | 1 | Port power-enable event (one-cycle pulse) |
| port_off_i | input | 1 | Port turned off or disabled by command (pulse) |
| cls_a_i | input | 4 | Assigned class, channel A |
| cls_b_i | input | 4 | Assigned class, channel B |
| dual_sig_i | input | 1 | Load is dual-signature |
| keep_host_i | input | 1 | Keep the host-written code at power-on |
| pol4_en_i | input | 1 | Four-pair policing enable for dual-signature loads |
| tick_i | input | 1 | 1 ms tick enable |
| ovld_ms_i | input | 8 | Configured overload time in ms |
| pwr_meas_i | input | 10 | Measured summed power, 0.5 W units |
| overload_o | output | 1 | Armed and power above effective threshold |
| fault_o | output | 1 | One-cycle power-cut fault pulse |
| pol_active_o | output | 1 | Policing armed |

## Verification
The assertions assume that the power-on and port-off events are single-cycle strobes. They also assume the power sample is a settled digital value that changes only between clock edges. The clamp and strict-compare checks depend on the sample being held steady within a cycle. The bench therefore drives every input at the falling edge, one value per cycle, and pulses each event for exactly one cycle. The tick is also pulsed for a single cycle, so each pulse counts exactly one millisecond.

// File: rtl/ppol_pkg.sv
package ppol_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_MANUAL = 2'd1,
      MODE_SEMI   = 2'd2,
      MODE_AUTO   = 2'd3
   } ppol_mode_e;

   localparam int CLS_W  = 4;
   localparam int CODE_W = 8;

   // Class-to-threshold code in 0.5 W steps; unknown classes give no limit.
   function automatic logic [CODE_W-1:0] class_code(input logic [CLS_W-1:0] cls);
      logic [CODE_W-1:0] c;
      case (cls)
         4'd1:    c = 8'h08;
         4'd2:    c = 8'h0E;
         4'd3:    c = 8'h1F;
         4'd4:    c = 8'h3C;
         4'd5:    c = 8'h5A;
         4'd6:    c = 8'h78;
         4'd7:    c = 8'h96;
         4'd8:    c = 8'hB4;
         default: c = 8'hFF;
      endcase
      return c;
   endfunction

   function automatic logic mode_is_auto(input ppol_mode_e m);
      return (m == MODE_SEMI) || (m == MODE_AUTO);
   endfunction

endpackage

// File: rtl/ppol_class_rom.sv
module ppol_class_rom
   import ppol_pkg::*;
#(
   parameter int THR_W   = 8,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic [CLS_W-1:0] cls_a_i,
   input  logic [CLS_W-1:0] cls_b_i,
   input  logic             dual_i,
   output logic [THR_W-1:0] code_o
);

   localparam int SUM_W = THR_W + 1;

   logic [THR_W-1:0] code_a;
   assign code_a = THR_W'(class_code(cls_a_i));

   generate
      if (DUAL_EN) begin : g_dual
         logic [THR_W-1:0] code_b;
         logic [SUM_W-1:0] sum;
         assign code_b = THR_W'(class_code(cls_b_i));
         assign sum    = {1'b0, code_a} + {1'b0, code_b};
         always_comb begin
            if (!dual_i)
               code_o = code_a;
            else if (sum[SUM_W-1])
               code_o = '1;
            else
               code_o = sum[THR_W-1:0];
         end
      end else begin : g_single
         logic unused_b;
         assign unused_b = ^{cls_b_i, dual_i};
         assign code_o   = code_a;
      end
   endgenerate

endmodule

// File: rtl/ppol_thr_reg.sv
module ppol_thr_reg #(
   parameter int THR_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [THR_W-1:0] wdata_i,
   input  logic             load_i,
   input  logic [THR_W-1:0] ldata_i,
   output logic [THR_W-1:0] q_o
);

   logic [THR_W-1:0] q_d, q_q;

   // Priority: port-off/fault clear, then host write, then class load.
   always_comb begin
      q_d = q_q;
      if (clr_i)
         q_d = '1;
      else if (wr_i)
         q_d = wdata_i;
      else if (load_i)
         q_d = ldata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         q_q <= '1;
      else
         q_q <= q_d;
   end

   assign q_o = q_q;

endmodule

// File: rtl/ppol_ovld_timer.sv
module ppol_ovld_timer #(
   parameter int THR_W    = 8,
   parameter int PWR_W    = 10,
   parameter int TMR_W    = 8,
   parameter int EXTRA_MS = 6,
   parameter int MIN_CODE = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic [PWR_W-1:0] pwr_i,
   input  logic             tick_i,
   input  logic [TMR_W-1:0] ovld_ms_i,
   output logic             over_o,
   output logic             fire_o,
   output logic             fault_o
);

   localparam int CMP_W = (THR_W > PWR_W) ? THR_W : PWR_W;
   localparam int CNT_W = TMR_W + $clog2(EXTRA_MS + 2) + 1;

   logic [CMP_W-1:0] eff_thr, pwr_ext;
   logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
   logic             fault_q;

   // Floor the compared threshold at the minimum code; readback is untouched.
   always_comb begin
      if (thr_i < THR_W'(MIN_CODE))
         eff_thr = CMP_W'(MIN_CODE);
      else
         eff_thr = CMP_W'(thr_i);
   end

   assign pwr_ext = CMP_W'(pwr_i);
   assign over_o  = arm_i && (pwr_ext > eff_thr);

   assign limit   = CNT_W'(ovld_ms_i) + CNT_W'(EXTRA_MS);
   assign cnt_inc = cnt_q + CNT_W'(1);
   assign fire_o  = over_o && tick_i && (cnt_inc >= limit);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fire_o;
         if (!over_o || fire_o)
            cnt_q <= '0;
         else if (tick_i)
            cnt_q <= cnt_inc;
      end
   end

   assign fault_o = fault_q;

endmodule

// File: rtl/ppol_ctrl.sv
module ppol_ctrl
   import ppol_pkg::*;
#(
   parameter int THR_W    = 8,
   parameter int PWR_W    = 10,
   parameter int TMR_W    = 8,
   parameter int EXTRA_MS = 6,
   parameter int MIN_CODE = 8,
   parameter bit DUAL_EN  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_wr_i,
   input  logic [THR_W-1:0] host_wdata_i,
   output logic [THR_W-1:0] thr_o,
   input  logic [1:0]       mode_i,
   input  logic             pwr_on_i,
   input  logic             port_off_i,
   input  logic [CLS_W-1:0] cls_a_i,
   input  logic [CLS_W-1:0] cls_b_i,
   input  logic             dual_sig_i,
   input  logic             keep_host_i,
   input  logic             pol4_en_i,
   input  logic             tick_i,
   input  logic [TMR_W-1:0] ovld_ms_i,
   input  logic [PWR_W-1:0] pwr_meas_i,
   output logic             overload_o,
   output logic             fault_o,
   output logic             pol_active_o
);

   generate
      if (THR_W < CODE_W) begin : g_chk_thr
         $error("THR_W must hold the 8-bit class codes");
      end
      if (MIN_CODE >= (1 << THR_W)) begin : g_chk_min
         $error("MIN_CODE does not fit THR_W");
      end
      if (EXTRA_MS < 0) begin : g_chk_extra
         $error("EXTRA_MS must not be negative");
      end
   endgenerate

   ppol_mode_e       mode;
   logic             auto_mode, powered_q, arm, fire, class_load, clr;
   logic [THR_W-1:0] class_def;

   assign mode      = ppol_mode_e'(mode_i);
   assign auto_mode = mode_is_auto(mode);

   ppol_class_rom #(
      .THR_W   (THR_W),
      .DUAL_EN (DUAL_EN)
   ) rom_i (
      .cls_a_i (cls_a_i),
      .cls_b_i (cls_b_i),
      .dual_i  (dual_sig_i),
      .code_o  (class_def)
   );

   assign clr        = port_off_i || fire;
   assign class_load = pwr_on_i && auto_mode && !keep_host_i;

   ppol_thr_reg #(
      .THR_W (THR_W)
   ) thr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .wr_i    (host_wr_i),
      .wdata_i (host_wdata_i),
      .load_i  (class_load),
      .ldata_i (class_def),
      .q_o     (thr_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         powered_q <= 1'b0;
      else if (clr)
         powered_q <= 1'b0;
      else if (pwr_on_i)
         powered_q <= 1'b1;
   end

   assign arm = powered_q && auto_mode && (!dual_sig_i || pol4_en_i);

   ppol_ovld_timer #(
      .THR_W    (THR_W),
      .PWR_W    (PWR_W),
      .TMR_W    (TMR_W),
      .EXTRA_MS (EXTRA_MS),
      .MIN_CODE (MIN_CODE)
   ) tmr_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arm_i     (arm),
      .thr_i     (thr_o),
      .pwr_i     (pwr_meas_i),
      .tick_i    (tick_i),
      .ovld_ms_i (ovld_ms_i),
      .over_o    (overload_o),
      .fire_o    (fire),
      .fault_o   (fault_o)
   );

   assign pol_active_o = arm;

endmodule

// File: rtl/ppol_ctrl_chk.sv
module ppol_ctrl_chk #(
   parameter int THR_W    = 8,
   parameter int PWR_W    = 10,
   parameter int MIN_CODE = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             host_wr_i,
   input logic [THR_W-1:0] host_wdata_i,
   input logic             port_off_i,
   input logic [1:0]       mode_i,
   input logic [PWR_W-1:0] pwr_meas_i,
   input logic [THR_W-1:0] thr_o,
   input logic             overload_o,
   input logic             fault_o
);

   localparam int EXT_W = THR_W + PWR_W;

   // R2: a host write without a same-cycle clear lands in the register
   assert_host_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && !port_off_i) |=> ((thr_o == $past(host_wdata_i)) || fault_o));

   // R7: port-off returns the code to all-ones
   assert_off_resets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_off_i |=> (thr_o == '1));

   // R7: a fault is accompanied by the reset code
   assert_fault_resets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (thr_o == '1));

   // R8: power at or below the floor never overloads
   assert_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (EXT_W'(pwr_meas_i) <= EXT_W'(MIN_CODE)) |-> !overload_o);

   // R9: overload implies power strictly above the stored code
   assert_strict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overload_o |-> (EXT_W'(pwr_meas_i) > EXT_W'(thr_o)));

   // R10: the fault is a single-cycle pulse
   assert_fault_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> !fault_o);

   // R11: no fault can follow a cycle without overload
   assert_no_fault_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !overload_o |=> !fault_o);

   // R12: manual or off mode never polices
   assert_manual_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i < 2'd2) |-> !overload_o);

endmodule

bind ppol_ctrl ppol_ctrl_chk #(
   .THR_W    (THR_W),
   .PWR_W    (PWR_W),
   .MIN_CODE (MIN_CODE)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .host_wr_i    (host_wr_i),
   .host_wdata_i (host_wdata_i),
   .port_off_i   (port_off_i),
   .mode_i       (mode_i),
   .pwr_meas_i   (pwr_meas_i),
   .thr_o        (thr_o),
   .overload_o   (overload_o),
   .fault_o      (fault_o)
);

// File: tb/ppol_ctrl_tb.sv
module ppol_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 14;

   // {mode[1:0], class A[3:0], class B[3:0], dual, keep, expected code[7:0]}
   localparam logic [19:0] VEC [NVEC] = '{
      {2'd3, 4'd1, 4'd0, 1'b0, 1'b0, 8'h08},
      {2'd3, 4'd2, 4'd0, 1'b0, 1'b0, 8'h0E},
      {2'd3, 4'd3, 4'd0, 1'b0, 1'b0, 8'h1F},
      {2'd3, 4'd4, 4'd0, 1'b0, 1'b0, 8'h3C},
      {2'd3, 4'd5, 4'd0, 1'b0, 1'b0, 8'h5A},
      {2'd3, 4'd6, 4'd0, 1'b0, 1'b0, 8'h78},
      {2'd3, 4'd7, 4'd0, 1'b0, 1'b0, 8'h96},
      {2'd3, 4'd8, 4'd0, 1'b0, 1'b0, 8'hB4},
      {2'd2, 4'd3, 4'd0, 1'b0, 1'b0, 8'h1F},
      {2'd3, 4'd0, 4'd0, 1'b0, 1'b0, 8'hFF},
      {2'd1, 4'd4, 4'd0, 1'b0, 1'b0, 8'h33},
      {2'd3, 4'd4, 4'd0, 1'b0, 1'b1, 8'h33},
      {2'd3, 4'd4, 4'd4, 1'b1, 1'b0, 8'h78},
      {2'd3, 4'd8, 4'd8, 1'b1, 1'b0, 8'hFF}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] thr;
   logic [1:0] mode = 2'd3;
   logic       pwr_on = 1'b0;
   logic       port_off = 1'b0;
   logic [3:0] cls_a = '0;
   logic [3:0] cls_b = '0;
   logic       dual = 1'b0;
   logic       keep = 1'b0;
   logic       pol4_en = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] ovld_ms = 8'd2;
   logic [9:0] pwr = '0;
   logic       overload, fault, active;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ppol_ctrl dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .host_wr_i    (host_wr),
      .host_wdata_i (host_wdata),
      .thr_o        (thr),
      .mode_i       (mode),
      .pwr_on_i     (pwr_on),
      .port_off_i   (port_off),
      .cls_a_i      (cls_a),
      .cls_b_i      (cls_b),
      .dual_sig_i   (dual),
      .keep_host_i  (keep),
      .pol4_en_i    (pol4_en),
      .tick_i       (tick),
      .ovld_ms_i    (ovld_ms),
      .pwr_meas_i   (pwr),
      .overload_o   (overload),
      .fault_o      (fault),
      .pol_active_o (active)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic off_pulse();
      port_off = 1'b1; cyc(); port_off = 1'b0;
   endtask

   task automatic write_thr(input logic [7:0] v);
      host_wr = 1'b1; host_wdata = v; cyc(); host_wr = 1'b0;
   endtask

   task automatic on_pulse();
      pwr_on = 1'b1; cyc(); pwr_on = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; cyc(); tick = 1'b0;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      check("R1 thr", thr, 8'hFF);
      check("R1 fault", fault, 0);
      check("R1 overload", overload, 0);
      check("R1 active", active, 0);

      // Table: class loading, dual sums, keep and manual (R3 R4 R5)
      for (int v = 0; v < NVEC; v++) begin
         off_pulse();
         write_thr(8'h33);
         mode  = VEC[v][19:18];
         cls_a = VEC[v][17:14];
         cls_b = VEC[v][13:10];
         dual  = VEC[v][9];
         keep  = VEC[v][8];
         on_pulse();
         check($sformatf("R3/R4/R5 vector %0d", v), thr, VEC[v][7:0]);
      end
      dual = 1'b0; keep = 1'b0; mode = 2'd3; cls_b = '0;

      // R2 readback of a code below the floor
      write_thr(8'h05);
      check("R2 readback", thr, 8'h05);

      // R6 host write beats class load
      off_pulse();
      cls_a = 4'd4; host_wr = 1'b1; host_wdata = 8'h40; pwr_on = 1'b1;
      cyc();
      host_wr = 1'b0; pwr_on = 1'b0;
      check("R6 write priority", thr, 8'h40);

      // R7 port-off beats host write, then plain off
      port_off = 1'b1; host_wr = 1'b1; host_wdata = 8'h22;
      cyc();
      port_off = 1'b0; host_wr = 1'b0;
      check("R7 off priority", thr, 8'hFF);
      check("R7 inactive after off", active, 0);

      // R8 floor and R9 strict compare
      cls_a = 4'd1; on_pulse();
      check("R12 armed", active, 1);
      write_thr(8'h03);
      pwr = 10'd8; #1;
      check("R8 at floor", overload, 0);
      pwr = 10'd9; #1;
      check("R8 above floor", overload, 1);
      write_thr(8'h20);
      pwr = 10'h20; #1;
      check("R9 equal", overload, 0);
      pwr = 10'h21; #1;
      check("R9 above", overload, 1);

      // R12 dual-signature without enable, then with enable, then manual
      dual = 1'b1; #1;
      check("R12 dual disabled", overload, 0);
      pol4_en = 1'b1; #1;
      check("R12 dual enabled", overload, 1);
      dual = 1'b0; pol4_en = 1'b0;
      mode = 2'd1; pwr = 10'h30;
      tick_n(10);
      check("R12 manual no overload", overload, 0);
      check("R12 manual no fault", fault, 0);
      check("R12 manual keeps code", thr, 8'h20);
      mode = 2'd3;

      // R11 timer restart; limit = 2 + 6 = 8 ticks
      tick_n(5);
      pwr = 10'h20; cyc();
      pwr = 10'h30;
      tick_n(7);
      check("R11 no fault after restart", fault, 0);
      check("R11 code kept", thr, 8'h20);
      // R10 eighth tick fires
      tick_n(1);
      check("R10 fault pulse", fault, 1);
      check("R7 fault resets code", thr, 8'hFF);
      cyc();
      check("R10 single cycle", fault, 0);
      check("R12 unpowered after fault", active, 0);
      #1;
      check("R12 unpowered no overload", overload, 0);

      finish_run();
   end

endmodule